// File: doc/BRIEF.md
# MOESI Line Coherence Controller

This block holds the coherence state of a single cache line in one of five states: Modified, Owned, Exclusive, Shared and Invalid. Two parties drive it. The processor side presents loads, stores, atomics, instruction-fetch misses, prefetches and victim notices. The system side presents snoops. When a processor event needs the bus, the controller raises a port request and holds it. It moves the line to its next state only when the matching system reply arrives.

Snoops are answered with one of two acknowledgment pulses. The first form means the line will supply copyback data. The second means no data will follow. In the data case the controller waits for a copyback-go reply. It then pulses a data-release strobe and applies the snoop's effect to the line state as it stands at that moment. The Owned state lets a dirty line be read by other caches without first writing it back to memory. A writeback can end with a release of the data or with a cancel, which sends no data.

Tag lookup, data storage, victim selection and bus arbitration are done by the surrounding logic. That logic owns the one line that this instance tracks.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset the line state is Invalid (code 0), no request is pending, both ready outputs are high and no pulse output is high. State codes are Invalid 0, Shared 1, Exclusive 2, Owned 3, Modified 4.
- R2: A load (op 0) or a prefetch (op 4) on an Invalid line raises a shared-read request (kind 1). Reply code 1 (exclusive data) then makes the line Exclusive, and reply code 2 (shared data) makes it Shared. The new state is visible in the cycle after the reply edge.
- R3: An instruction-fetch miss (op 3) on an Invalid line raises an always-shared read request (kind 2). Only reply 2 completes it, and the line ends in Shared.
- R4: A store (op 1) or an atomic (op 2) on an Invalid line raises a read-for-ownership request (kind 3). Reply 1 makes the line Modified.
- R5: A store or atomic on an Exclusive line moves it to Modified on the accepting edge, with no request. A store on a Modified line, or a load on any valid line, raises no request and leaves the state unchanged.
- R6: A store or atomic on a Shared or Owned line raises a read-for-ownership request (kind 3). An ownership grant (reply 3) then makes the line Modified.
- R7: A victim notice (op 5) on a Modified or Owned line raises a writeback request (kind 4). Reply 4 moves the line to Invalid and pulses wb_data_go for one cycle. Reply 5 (cancel) moves the line to Invalid with no pulse.
- R8: A victim notice on an Exclusive or Shared line moves it to Invalid on the accepting edge with no request. On an Invalid line it has no effect.
- R9: A copyback-type snoop (kinds 0, 1, 2) on an Exclusive, Modified or Owned line pulses snp_ack_data. The controller then waits for reply 6, which pulses cpb_data_go and applies the state change on the same edge. Every other snoop pulses snp_ack_nodata and applies its change on the accepting edge.
- R10: Snoop effects are as follows. Kind 0 (copy, memory not updated) moves Exclusive to Shared and Modified to Owned. Kind 1 (copy with memory update) moves Exclusive, Modified and Owned to Shared. Kind 2 (copy and invalidate) and kind 3 (invalidate) move every state to Invalid. Any state not named keeps its value.
- R11: While a request or a copyback is pending, cpu_ready is low and processor events are ignored. While a copyback is pending, snp_ready is low. A pending request's kind does not change.
- R12: A snoop accepted in the same cycle as a processor event causes that processor event to be dropped. Snoops are accepted while a request is pending. If a snoop commit and a reply commit fall on the same edge, the snoop's result is the one kept.
- R13: A reply code that does not match the pending request is ignored, and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor event present |
| cpu_op | input | 3 | Processor event code (0 load, 1 store, 2 atomic, 3 fetch miss, 4 prefetch, 5 victim) |
| cpu_ready | output | 1 | Processor events accepted this cycle |
| snp_valid | input | 1 | Snoop present |
| snp_kind | input | 2 | Snoop kind (0 copy, 1 copy with memory update, 2 copy and invalidate, 3 invalidate) |
| snp_ready | output | 1 | Snoops accepted this cycle |
| snp_ack_data | output | 1 | One-cycle snoop acknowledgment, data follows |
| snp_ack_nodata | output | 1 | One-cycle snoop acknowledgment, no data |
| req_valid | output | 1 | Port request pending |
| req_kind | output | 3 | Pending request kind (1 shared read, 2 always-shared read, 3 read for ownership, 4 writeback) |
| rply_valid | input | 1 | System reply present |
| rply_code | input | 3 | Reply code (1 exclusive data, 2 shared data, 3 ownership grant, 4 writeback go, 5 writeback cancel, 6 copyback go) |
| cpb_data_go | output | 1 | One-cycle strobe: release copyback data |
| wb_data_go | output | 1 | One-cycle strobe: release writeback data |
| line_state | output | 3 | Current coherence state |

## Verification
The assertions check the following on every cycle:
- the line state always holds a legal code;
- the two acknowledgment forms never fire together;
- a pending request blocks the processor side and keeps its kind;
- the data strobes appear only after a pending writeback or copyback;
- the Exclusive-store, clean-victim and invalidate transitions land in the cycle after acceptance.

The following can only be shown by the bench's scenarios:
- full request and reply sequences;
- Modified-to-Owned sharing followed by an upgrade;
- a writeback that a copy-and-invalidate snoop overtakes and the system then cancels;
- mismatched replies being ignored;
- the precedence rules when a snoop collides with a processor event or with a reply.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  localparam int ST_W = 3;
  localparam int OP_W = 3;
  localparam int SK_W = 2;
  localparam int RQ_W = 3;
  localparam int RP_W = 3;

  typedef enum logic [ST_W-1:0] {
    LN_I = 3'd0,
    LN_S = 3'd1,
    LN_E = 3'd2,
    LN_O = 3'd3,
    LN_M = 3'd4
  } line_st_e;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD     = 3'd0,
    OP_STORE    = 3'd1,
    OP_ATOMIC   = 3'd2,
    OP_IFETCH   = 3'd3,
    OP_PREFETCH = 3'd4,
    OP_VICTIM   = 3'd5
  } cpu_op_e;

  typedef enum logic [SK_W-1:0] {
    SN_COPY       = 2'd0,
    SN_COPY_CLEAN = 2'd1,
    SN_COPY_INV   = 2'd2,
    SN_INVAL      = 2'd3
  } snp_e;

  typedef enum logic [RQ_W-1:0] {
    RQ_NONE       = 3'd0,
    RQ_RD_SHR     = 3'd1,
    RQ_RD_SHR_ALW = 3'd2,
    RQ_RD_OWN     = 3'd3,
    RQ_WBACK      = 3'd4
  } req_e;

  typedef enum logic [RP_W-1:0] {
    RP_NONE      = 3'd0,
    RP_DATA_EXCL = 3'd1,
    RP_DATA_SHR  = 3'd2,
    RP_OWN_GRANT = 3'd3,
    RP_WB_GO     = 3'd4,
    RP_WB_CANCEL = 3'd5,
    RP_CPB_GO    = 3'd6
  } rply_e;

  // Line holds data the system must fetch from this cache
  function automatic logic holds_data(line_st_e s);
    return (s == LN_E) || (s == LN_M) || (s == LN_O);
  endfunction

  function automatic logic snoop_needs_data(snp_e k, line_st_e s);
    return (k != SN_INVAL) && holds_data(s);
  endfunction

  function automatic line_st_e snoop_target(snp_e k, line_st_e s);
    line_st_e t;
    t = s;
    case (k)
      SN_COPY: begin
        if (s == LN_E) t = LN_S;
        else if (s == LN_M) t = LN_O;
      end
      SN_COPY_CLEAN: begin
        if (holds_data(s)) t = LN_S;
      end
      default: t = LN_I;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/moesi_proc_side.sv
module moesi_proc_side
  import moesi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  cpu_op_e  op,
  input  line_st_e cur_st,
  input  logic     rply_valid,
  input  rply_e    rply,
  output logic     busy,
  output logic     req_valid,
  output req_e     req_kind,
  output logic     commit,
  output line_st_e commit_st,
  output logic     wb_go
);

  logic     pend_q, pend_d;
  req_e     kind_q, kind_d;
  logic     wb_go_q;
  logic     upd_en;

  logic     dir_vld;
  line_st_e dir_st;
  req_e     new_req;

  logic     rp_hit;
  line_st_e rp_st;
  logic     rp_wb;

  // Decode of an accepted processor event against the current state
  always_comb begin
    dir_vld = 1'b0;
    dir_st  = cur_st;
    new_req = RQ_NONE;
    case (op)
      OP_LOAD, OP_PREFETCH: begin
        if (cur_st == LN_I) new_req = RQ_RD_SHR;
      end
      OP_IFETCH: begin
        if (cur_st == LN_I) new_req = RQ_RD_SHR_ALW;
      end
      OP_STORE, OP_ATOMIC: begin
        case (cur_st)
          LN_I, LN_S, LN_O: new_req = RQ_RD_OWN;
          LN_E: begin
            dir_vld = 1'b1;
            dir_st  = LN_M;
          end
          default: ;
        endcase
      end
      OP_VICTIM: begin
        case (cur_st)
          LN_M, LN_O: new_req = RQ_WBACK;
          LN_E, LN_S: begin
            dir_vld = 1'b1;
            dir_st  = LN_I;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  // Match a system reply against the pending request
  always_comb begin
    rp_hit = 1'b0;
    rp_st  = LN_I;
    rp_wb  = 1'b0;
    if (pend_q && rply_valid) begin
      case (kind_q)
        RQ_RD_SHR: begin
          if (rply == RP_DATA_EXCL) begin
            rp_hit = 1'b1;
            rp_st  = LN_E;
          end else if (rply == RP_DATA_SHR) begin
            rp_hit = 1'b1;
            rp_st  = LN_S;
          end
        end
        RQ_RD_SHR_ALW: begin
          if (rply == RP_DATA_SHR) begin
            rp_hit = 1'b1;
            rp_st  = LN_S;
          end
        end
        RQ_RD_OWN: begin
          if (rply == RP_DATA_EXCL || rply == RP_OWN_GRANT) begin
            rp_hit = 1'b1;
            rp_st  = LN_M;
          end
        end
        RQ_WBACK: begin
          if (rply == RP_WB_GO) begin
            rp_hit = 1'b1;
            rp_wb  = 1'b1;
          end else if (rply == RP_WB_CANCEL) begin
            rp_hit = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    pend_d = pend_q;
    kind_d = kind_q;
    if (rp_hit) begin
      pend_d = 1'b0;
      kind_d = RQ_NONE;
    end else if (take && !pend_q && new_req != RQ_NONE) begin
      pend_d = 1'b1;
      kind_d = new_req;
    end
  end

  assign upd_en = rp_hit || (take && !pend_q && new_req != RQ_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      kind_q  <= RQ_NONE;
      wb_go_q <= 1'b0;
    end else begin
      if (upd_en) begin
        pend_q <= pend_d;
        kind_q <= kind_d;
      end
      wb_go_q <= rp_wb;
    end
  end

  assign busy      = pend_q;
  assign req_valid = pend_q;
  assign req_kind  = kind_q;
  assign commit    = rp_hit || (take && dir_vld);
  assign commit_st = rp_hit ? rp_st : dir_st;
  assign wb_go     = wb_go_q;

endmodule

// File: rtl/moesi_snoop_side.sv
module moesi_snoop_side
  import moesi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  snp_e     kind,
  input  line_st_e cur_st,
  input  logic     rply_valid,
  input  rply_e    rply,
  output logic     busy,
  output logic     ack_data,
  output logic     ack_nodata,
  output logic     cpb_go,
  output logic     commit,
  output line_st_e commit_st
);

  logic wait_q, wait_d;
  snp_e kind_q;
  logic ackd_q, ackn_q, cpb_q;
  logic need;
  logic finish;

  assign need   = snoop_needs_data(kind, cur_st);
  assign finish = wait_q && rply_valid && (rply == RP_CPB_GO);

  always_comb begin
    wait_d = wait_q;
    if (finish)              wait_d = 1'b0;
    else if (take && need)   wait_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      kind_q <= SN_INVAL;
      ackd_q <= 1'b0;
      ackn_q <= 1'b0;
      cpb_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      if (take) kind_q <= kind;
      ackd_q <= take && need;
      ackn_q <= take && !need;
      cpb_q  <= finish;
    end
  end

  // A data snoop applies its effect to the state current at completion
  assign commit    = finish || (take && !need);
  assign commit_st = finish ? snoop_target(kind_q, cur_st) : snoop_target(kind, cur_st);
  assign busy       = wait_q;
  assign ack_data   = ackd_q;
  assign ack_nodata = ackn_q;
  assign cpb_go     = cpb_q;

endmodule

// File: rtl/moesi_line_reg.sv
module moesi_line_reg
  import moesi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snp_commit,
  input  line_st_e snp_st,
  input  logic     prc_commit,
  input  line_st_e prc_st,
  output line_st_e st_q
);

  logic     st_en;
  line_st_e st_d;

  // Snoop result takes precedence over a same-edge reply result
  always_comb begin
    st_en = snp_commit || prc_commit;
    st_d  = snp_commit ? snp_st : prc_st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= LN_I;
    else if (st_en)  st_q <= st_d;
  end

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  input  logic [OP_W-1:0] cpu_op,
  output logic            cpu_ready,
  input  logic            snp_valid,
  input  logic [SK_W-1:0] snp_kind,
  output logic            snp_ready,
  output logic            snp_ack_data,
  output logic            snp_ack_nodata,
  output logic            req_valid,
  output logic [RQ_W-1:0] req_kind,
  input  logic            rply_valid,
  input  logic [RP_W-1:0] rply_code,
  output logic            cpb_data_go,
  output logic            wb_data_go,
  output logic [ST_W-1:0] line_state
);

  line_st_e cur_st;
  logic     prc_busy, snp_busy;
  logic     cpu_take, snp_take;
  logic     prc_commit, snp_commit;
  line_st_e prc_st, snp_st;
  req_e     prc_kind;

  assign snp_ready = !snp_busy;
  assign cpu_ready = !prc_busy && !snp_busy;
  assign snp_take  = snp_valid && snp_ready;
  assign cpu_take  = cpu_valid && cpu_ready && !snp_valid;

  moesi_proc_side u_proc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (cpu_take),
    .op         (cpu_op_e'(cpu_op)),
    .cur_st     (cur_st),
    .rply_valid (rply_valid),
    .rply       (rply_e'(rply_code)),
    .busy       (prc_busy),
    .req_valid  (req_valid),
    .req_kind   (prc_kind),
    .commit     (prc_commit),
    .commit_st  (prc_st),
    .wb_go      (wb_data_go)
  );

  moesi_snoop_side u_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (snp_take),
    .kind       (snp_e'(snp_kind)),
    .cur_st     (cur_st),
    .rply_valid (rply_valid),
    .rply       (rply_e'(rply_code)),
    .busy       (snp_busy),
    .ack_data   (snp_ack_data),
    .ack_nodata (snp_ack_nodata),
    .cpb_go     (cpb_data_go),
    .commit     (snp_commit),
    .commit_st  (snp_st)
  );

  moesi_line_reg u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_commit (snp_commit),
    .snp_st     (snp_st),
    .prc_commit (prc_commit),
    .prc_st     (prc_st),
    .st_q       (cur_st)
  );

  assign req_kind   = prc_kind;
  assign line_state = cur_st;

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk
  import moesi_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_valid,
  input logic [OP_W-1:0] cpu_op,
  input logic            cpu_ready,
  input logic            snp_valid,
  input logic [SK_W-1:0] snp_kind,
  input logic            snp_ready,
  input logic            snp_ack_data,
  input logic            snp_ack_nodata,
  input logic            req_valid,
  input logic [RQ_W-1:0] req_kind,
  input logic            cpb_data_go,
  input logic            wb_data_go,
  input logic [ST_W-1:0] line_state
);

  logic cpu_acc;
  assign cpu_acc = cpu_valid && cpu_ready && !snp_valid;

  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    line_state <= 3'd4)
    else $error("a_r1_legal_state: illegal code %0d", line_state);

  a_r5_store_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_acc && (cpu_op == OP_STORE || cpu_op == OP_ATOMIC) && line_state == LN_E)
    |=> (line_state == LN_M && !req_valid))
    else $error("a_r5_store_excl");

  a_r7_wb_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wb_data_go |-> $past(req_valid && req_kind == RQ_WBACK))
    else $error("a_r7_wb_strobe");

  a_r8_clean_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_acc && cpu_op == OP_VICTIM && (line_state == LN_E || line_state == LN_S))
    |=> (line_state == LN_I && !req_valid))
    else $error("a_r8_clean_victim");

  a_r9_ack_forms: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_ack_data && snp_ack_nodata))
    else $error("a_r9_ack_forms");

  a_r9_cpb_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    cpb_data_go |-> $past(!snp_ready))
    else $error("a_r9_cpb_after_wait");

  a_r10_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready && snp_kind == SN_INVAL)
    |=> (line_state == LN_I && snp_ack_nodata))
    else $error("a_r10_invalidate");

  a_r11_pend_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cpu_ready)
    else $error("a_r11_pend_blocks");

  a_r11_kind_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid)) |-> $stable(req_kind))
    else $error("a_r11_kind_hold");

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_valid      (cpu_valid),
  .cpu_op         (cpu_op),
  .cpu_ready      (cpu_ready),
  .snp_valid      (snp_valid),
  .snp_kind       (snp_kind),
  .snp_ready      (snp_ready),
  .snp_ack_data   (snp_ack_data),
  .snp_ack_nodata (snp_ack_nodata),
  .req_valid      (req_valid),
  .req_kind       (req_kind),
  .cpb_data_go    (cpb_data_go),
  .wb_data_go     (wb_data_go),
  .line_state     (line_state)
);

// File: tb/tb_moesi_line_ctrl.sv
module tb_moesi_line_ctrl;
  import moesi_pkg::*;

  localparam int EV_REQ = 0, EV_ACKD = 1, EV_ACKN = 2, EV_CPB = 3, EV_WB = 4, EV_ST = 5;

  logic       clk, rst_n;
  logic       cpu_valid, snp_valid, rply_valid;
  logic [2:0] cpu_op, rply_code;
  logic [1:0] snp_kind;
  logic       cpu_ready, snp_ready, snp_ack_data, snp_ack_nodata;
  logic       req_valid, cpb_data_go, wb_data_go;
  logic [2:0] req_kind, line_state;

  typedef struct {
    int    kind;
    int    val;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;

  moesi_line_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_ready(cpu_ready),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_ready(snp_ready),
    .snp_ack_data(snp_ack_data), .snp_ack_nodata(snp_ack_nodata),
    .req_valid(req_valid), .req_kind(req_kind),
    .rply_valid(rply_valid), .rply_code(rply_code),
    .cpb_data_go(cpb_data_go), .wb_data_go(wb_data_go),
    .line_state(line_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_ev(int k, int v, string tag);
    exp_q.push_back('{kind: k, val: v, tag: tag});
  endtask

  task automatic observe(int k, int v);
    exp_t e;
    if (exp_q.size() == 0) begin
      check(0, "unexpected event", k * 16 + v, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k && e.val == v, e.tag, k * 16 + v, e.kind * 16 + e.val);
    end
  endtask

  // Monitor: turns output activity into events and scores them
  initial begin
    logic       prev_req;
    logic [2:0] prev_st;
    prev_req = 1'b0;
    prev_st  = 3'd0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (req_valid && !prev_req) observe(EV_REQ, int'(req_kind));
        if (snp_ack_data)           observe(EV_ACKD, 0);
        if (snp_ack_nodata)         observe(EV_ACKN, 0);
        if (cpb_data_go)            observe(EV_CPB, 0);
        if (wb_data_go)             observe(EV_WB, 0);
        if (line_state != prev_st)  observe(EV_ST, int'(line_state));
        prev_req = req_valid;
        prev_st  = line_state;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cpu(logic [2:0] op);
    cpu_valid = 1'b1; cpu_op = op;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic do_snp(logic [1:0] k);
    snp_valid = 1'b1; snp_kind = k;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic do_rply(logic [2:0] c);
    rply_valid = 1'b1; rply_code = c;
    @(negedge clk);
    rply_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_valid = 1'b0; snp_valid = 1'b0; rply_valid = 1'b0;
    cpu_op = 3'd0; snp_kind = 2'd0; rply_code = 3'd0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check(line_state == 3'd0, "R1 state", line_state, 0);
    check(!req_valid, "R1 req_valid", req_valid, 0);
    check(cpu_ready && snp_ready, "R1 ready", {cpu_ready, snp_ready}, 3);
    check(!snp_ack_data && !snp_ack_nodata && !cpb_data_go && !wb_data_go,
          "R1 pulses", {snp_ack_data, snp_ack_nodata, cpb_data_go, wb_data_go}, 0);

    // R2 load miss, exclusive reply
    expect_ev(EV_REQ, 1, "R2 load request");
    do_cpu(OP_LOAD);
    expect_ev(EV_ST, 2, "R2 exclusive fill");
    do_rply(RP_DATA_EXCL);

    // R5 store on Exclusive, then store/load on Modified
    expect_ev(EV_ST, 4, "R5 store on E");
    do_cpu(OP_STORE);
    check(!req_valid, "R5 no request on E store", req_valid, 0);
    do_cpu(OP_STORE);
    do_cpu(OP_LOAD);
    check(line_state == 3'd4 && !req_valid, "R5 hits on M", line_state, 4);

    // R9 R10 copy snoop on Modified -> Owned; R11 blocking during copyback
    expect_ev(EV_ACKD, 0, "R9 data ack on M");
    do_snp(SN_COPY);
    check(!cpu_ready && !snp_ready, "R11 blocked during copyback", {cpu_ready, snp_ready}, 0);
    do_cpu(OP_VICTIM);
    check(!req_valid && line_state == 3'd4, "R11 event ignored", line_state, 4);
    step(1);
    expect_ev(EV_CPB, 0, "R9 copyback strobe");
    expect_ev(EV_ST, 3, "R10 M to O");
    do_rply(RP_CPB_GO);

    // R6 store on Owned
    expect_ev(EV_REQ, 3, "R6 upgrade from O");
    do_cpu(OP_STORE);
    expect_ev(EV_ST, 4, "R6 grant to M");
    do_rply(RP_OWN_GRANT);

    // R7 writeback completes
    expect_ev(EV_REQ, 4, "R7 writeback request");
    do_cpu(OP_VICTIM);
    expect_ev(EV_WB, 0, "R7 writeback strobe");
    expect_ev(EV_ST, 0, "R7 writeback to I");
    do_rply(RP_WB_GO);

    // R3 R13 fetch miss ignores exclusive reply
    expect_ev(EV_REQ, 2, "R3 fetch request");
    do_cpu(OP_IFETCH);
    do_rply(RP_DATA_EXCL);
    check(req_valid && req_kind == 3'd2, "R13 mismatched reply ignored", req_kind, 2);
    expect_ev(EV_ST, 1, "R3 shared fill");
    do_rply(RP_DATA_SHR);

    // R6 upgrade from Shared; R11 R13 during pending
    expect_ev(EV_REQ, 3, "R6 upgrade from S");
    do_cpu(OP_ATOMIC);
    do_cpu(OP_VICTIM);
    check(req_kind == 3'd3 && line_state == 3'd1, "R11 kind held", req_kind, 3);
    do_rply(RP_WB_GO);
    check(req_valid, "R13 writeback go ignored", req_valid, 1);
    expect_ev(EV_ST, 4, "R6 grant from S");
    do_rply(RP_OWN_GRANT);

    // R10 copy with memory update on M -> S
    expect_ev(EV_ACKD, 0, "R9 data ack clean copy");
    do_snp(SN_COPY_CLEAN);
    expect_ev(EV_CPB, 0, "R9 strobe clean copy");
    expect_ev(EV_ST, 1, "R10 M to S");
    do_rply(RP_CPB_GO);

    // R8 clean victim, then victim on I
    expect_ev(EV_ST, 0, "R8 S victim");
    do_cpu(OP_VICTIM);
    do_cpu(OP_VICTIM);
    check(!req_valid && line_state == 3'd0, "R8 victim on I", line_state, 0);

    // R4 atomic miss
    expect_ev(EV_REQ, 3, "R4 own request");
    do_cpu(OP_ATOMIC);
    expect_ev(EV_ST, 4, "R4 fill to M");
    do_rply(RP_DATA_EXCL);

    // R7 R12 writeback overtaken by copy-invalidate, then cancelled
    expect_ev(EV_REQ, 4, "R7 writeback request 2");
    do_cpu(OP_VICTIM);
    expect_ev(EV_ACKD, 0, "R12 snoop during writeback");
    do_snp(SN_COPY_INV);
    step(1);
    expect_ev(EV_CPB, 0, "R9 strobe copy-inv");
    expect_ev(EV_ST, 0, "R10 copy-inv to I");
    do_rply(RP_CPB_GO);
    do_rply(RP_WB_CANCEL);
    check(!req_valid && !wb_data_go && line_state == 3'd0, "R7 cancel", req_valid, 0);

    // R2 shared fill then R10 invalidate
    expect_ev(EV_REQ, 1, "R2 load request 2");
    do_cpu(OP_LOAD);
    expect_ev(EV_ST, 1, "R2 shared fill");
    do_rply(RP_DATA_SHR);
    expect_ev(EV_ACKN, 0, "R9 no-data ack on S");
    expect_ev(EV_ST, 0, "R10 invalidate S");
    do_snp(SN_INVAL);

    // R12 snoop and processor event together
    expect_ev(EV_ACKN, 0, "R12 snoop wins");
    cpu_valid = 1'b1; cpu_op = OP_LOAD; snp_valid = 1'b1; snp_kind = SN_INVAL;
    @(negedge clk);
    cpu_valid = 1'b0; snp_valid = 1'b0;
    step(1);
    check(!req_valid, "R12 processor event dropped", req_valid, 0);

    // R2 prefetch, R10 copy on Exclusive -> Shared
    expect_ev(EV_REQ, 1, "R2 prefetch request");
    do_cpu(OP_PREFETCH);
    expect_ev(EV_ST, 2, "R2 prefetch fill E");
    do_rply(RP_DATA_EXCL);
    expect_ev(EV_ACKD, 0, "R9 data ack on E");
    do_snp(SN_COPY);
    expect_ev(EV_CPB, 0, "R9 strobe on E");
    expect_ev(EV_ST, 1, "R10 E to S");
    do_rply(RP_CPB_GO);

    // Build Owned then cancelled writeback from O
    expect_ev(EV_REQ, 3, "R6 upgrade S again");
    do_cpu(OP_STORE);
    expect_ev(EV_ST, 4, "R6 grant again");
    do_rply(RP_OWN_GRANT);
    expect_ev(EV_ACKD, 0, "R9 ack M copy");
    do_snp(SN_COPY);
    expect_ev(EV_CPB, 0, "R9 strobe M copy");
    expect_ev(EV_ST, 3, "R10 M to O again");
    do_rply(RP_CPB_GO);
    expect_ev(EV_REQ, 4, "R7 writeback from O");
    do_cpu(OP_VICTIM);
    expect_ev(EV_ST, 0, "R7 cancel to I");
    do_rply(RP_WB_CANCEL);

    // R9 copy snoop on Invalid gets no-data ack
    expect_ev(EV_ACKN, 0, "R9 no-data ack on I");
    do_snp(SN_COPY);
    check(snp_ready, "R9 no wait on I", snp_ready, 1);

    // R12 same-edge snoop commit beats reply commit
    expect_ev(EV_REQ, 1, "R12 load before collision");
    do_cpu(OP_LOAD);
    expect_ev(EV_ACKN, 0, "R12 collision ack");
    snp_valid = 1'b1; snp_kind = SN_INVAL;
    rply_valid = 1'b1; rply_code = RP_DATA_EXCL;
    @(negedge clk);
    snp_valid = 1'b0; rply_valid = 1'b0;
    check(line_state == 3'd0 && !req_valid, "R12 snoop result kept", line_state, 0);

    step(3);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule